// File: doc/BRIEF.md
# Boot remap memory address decoder

This block sits on the internal memory bus and turns a 32-bit address into a select for one of three on-chip targets: boot ROM, flash or SRAM. The low 4 MB of address space is split into four 1 MB windows. Three of these windows always point at the same target. The lowest window, at address zero, is an alias. It points at the ROM or at the flash before a remap, and at the SRAM after one. Addresses in the rest of the first 256 MB raise an abort. Addresses above that belong to other decoders, and this block ignores them.

The alias target comes from two state bits held in the block. The first is a boot-select bit, which stands in for a non-volatile fuse. Set, clear and erase pulses change it, and its reset value is a parameter. The second is a remap latch that can only be set. Only reset clears it. A change to either bit takes effect at the next clock edge. The address decode itself is combinational from the registered state, so a select, offset or abort is valid in the same cycle as the address. Each target sees an offset folded to its own size, so a small memory repeats through its whole 1 MB window.

Top module: `boot_map_decoder`

## Requirements
- R1: When `valid_i` is high, the fixed windows decode the same way in every state. Address bits 31:20 of 0x001 give flash, 0x002 give SRAM and 0x003 give ROM. The select encoding is `sel_o[0]` = flash, `sel_o[1]` = SRAM, `sel_o[2]` = ROM.
- R2: When `valid_i` is high and the address is from 0x0040_0000 to 0x0FFF_FFFF, `abort_o` is 1 and `sel_o` is 0.
- R3: When the address is at or above 0x1000_0000, `sel_o` is 0 and `abort_o` is 0.
- R4: When `valid_i` is low, `sel_o`, `abort_o` and `offset_o` are all 0, whatever the address.
- R5: After reset, the boot-select bit equals `BOOT_DEFAULT` (default 0) and the remap latch is clear. With the default, the window at address zero selects the ROM.
- R6: Before a remap, with the boot-select bit at 1, the window at address zero selects the flash.
- R7: After a remap, the window at address zero selects the SRAM. SRAM stays reachable at 0x0020_0000.
- R8: The remap latch is cleared only by reset. Further remap pulses and any boot-select change leave the alias on SRAM.
- R9: `set_boot_i` sets the boot-select bit. `clr_boot_i` and `erase_i` each clear it. When a clear or erase pulse arrives together with a set pulse, the clear or erase wins.
- R10: A state change takes effect at the clock edge that samples the pulse. A decode in the same cycle as the pulse uses the old state.
- R11: `offset_o` is address bits 19:0 masked to the selected target's size: `ROM_AW`, `FLASH_AW` or `SRAM_AW` low bits, with defaults of 16, 18 and 16. It is 0 when no target is selected.
- R12: At most one bit of `sel_o` is high. `abort_o` is never high together with a select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 32 | Bus address |
| valid_i | input | 1 | Address valid strobe |
| remap_i | input | 1 | Remap command pulse |
| set_boot_i | input | 1 | Set boot-select bit pulse |
| clr_boot_i | input | 1 | Clear boot-select bit pulse |
| erase_i | input | 1 | Erase pulse, clears boot-select bit |
| sel_o | output | 3 | One-hot target select {ROM, SRAM, flash} |
| offset_o | output | 20 | Target-local offset |
| abort_o | output | 1 | Undefined-area abort |

## Verification
The select, offset and abort outputs are combinational from the address. The bench therefore drives an address shortly after the falling edge and samples 1 time unit later, within the same cycle. A command pulse changes the alias only after the rising edge that samples it. For each pulse, the bench first checks the decode in the pulse cycle, where the old target must still appear. It then checks the decode after the next falling edge, where the new target must appear. Reset acts asynchronously, so the ROM alias is checked while reset is still held.

// File: rtl/boot_map_pkg.sv
package boot_map_pkg;
  localparam int unsigned ADDR_W   = 32;
  localparam int unsigned REGION_W = 20;  // 1 MB window
  localparam int unsigned SPACE_W  = 28;  // 256 MB owned by this decoder
  localparam int unsigned MAP_W    = 22;  // 4 MB populated
  localparam int unsigned NUM_TGT  = 3;

  localparam int unsigned SEL_FLASH = 0;
  localparam int unsigned SEL_SRAM  = 1;
  localparam int unsigned SEL_ROM   = 2;

  typedef enum logic [1:0] {
    WIN_ALIAS = 2'd0,
    WIN_FLASH = 2'd1,
    WIN_SRAM  = 2'd2,
    WIN_ROM   = 2'd3
  } win_e;

  typedef enum logic [1:0] {
    TGT_NONE  = 2'd0,
    TGT_FLASH = 2'd1,
    TGT_SRAM  = 2'd2,
    TGT_ROM   = 2'd3
  } tgt_e;
endpackage

// File: rtl/boot_state.sv
module boot_state #(
  parameter logic BOOT_DEFAULT = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic remap_i,
  input  logic set_boot_i,
  input  logic clr_boot_i,
  input  logic erase_i,
  output logic boot_sel_o,
  output logic remapped_o
);
  logic boot_q, remap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      boot_q  <= BOOT_DEFAULT;
      remap_q <= 1'b0;
    end else begin
      // clear and erase dominate set
      if (clr_boot_i || erase_i) boot_q <= 1'b0;
      else if (set_boot_i)       boot_q <= 1'b1;
      if (remap_i) remap_q <= 1'b1;
    end
  end

  assign boot_sel_o = boot_q;
  assign remapped_o = remap_q;
endmodule

// File: rtl/addr_window.sv
module addr_window
  import boot_map_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              valid_i,
  output logic              hit_o,
  output logic              abort_o,
  output win_e              win_o
);
  logic in_space, in_map;

  assign in_space = (addr_i[ADDR_W-1:SPACE_W] == '0);
  assign in_map   = (addr_i[SPACE_W-1:MAP_W] == '0);
  assign hit_o    = valid_i && in_space && in_map;
  assign abort_o  = valid_i && in_space && !in_map;
  assign win_o    = win_e'(addr_i[MAP_W-1:REGION_W]);
endmodule

// File: rtl/alias_route.sv
module alias_route
  import boot_map_pkg::*;
(
  input  logic hit_i,
  input  win_e win_i,
  input  logic boot_sel_i,
  input  logic remapped_i,
  output tgt_e tgt_o
);
  always_comb begin
    tgt_o = TGT_NONE;
    if (hit_i) begin
      unique case (win_i)
        WIN_FLASH: tgt_o = TGT_FLASH;
        WIN_SRAM:  tgt_o = TGT_SRAM;
        WIN_ROM:   tgt_o = TGT_ROM;
        default:   tgt_o = remapped_i ? TGT_SRAM : (boot_sel_i ? TGT_FLASH : TGT_ROM);
      endcase
    end
  end
endmodule

// File: rtl/boot_map_decoder.sv
module boot_map_decoder
  import boot_map_pkg::*;
#(
  parameter int unsigned ROM_AW       = 16,
  parameter int unsigned FLASH_AW     = 18,
  parameter int unsigned SRAM_AW      = 16,
  parameter logic        BOOT_DEFAULT = 1'b0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                valid_i,
  input  logic                remap_i,
  input  logic                set_boot_i,
  input  logic                clr_boot_i,
  input  logic                erase_i,
  output logic [NUM_TGT-1:0]  sel_o,
  output logic [REGION_W-1:0] offset_o,
  output logic                abort_o
);
  localparam logic [REGION_W-1:0] ONES = {REGION_W{1'b1}};
  localparam logic [REGION_W-1:0] MASK [NUM_TGT] = '{
    ONES >> (REGION_W - FLASH_AW),
    ONES >> (REGION_W - SRAM_AW),
    ONES >> (REGION_W - ROM_AW)
  };
  localparam tgt_e TGT_OF [NUM_TGT] = '{TGT_FLASH, TGT_SRAM, TGT_ROM};

  logic boot_sel_q, remap_q, hit;
  win_e win;
  tgt_e tgt;
  logic [REGION_W-1:0] off_part [NUM_TGT];

  boot_state #(.BOOT_DEFAULT(BOOT_DEFAULT)) u_state (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .remap_i    (remap_i),
    .set_boot_i (set_boot_i),
    .clr_boot_i (clr_boot_i),
    .erase_i    (erase_i),
    .boot_sel_o (boot_sel_q),
    .remapped_o (remap_q)
  );

  addr_window u_win (
    .addr_i  (addr_i),
    .valid_i (valid_i),
    .hit_o   (hit),
    .abort_o (abort_o),
    .win_o   (win)
  );

  alias_route u_route (
    .hit_i      (hit),
    .win_i      (win),
    .boot_sel_i (boot_sel_q),
    .remapped_i (remap_q),
    .tgt_o      (tgt)
  );

  for (genvar g = 0; g < NUM_TGT; g++) begin : g_tgt
    assign sel_o[g]    = (tgt == TGT_OF[g]);
    assign off_part[g] = sel_o[g] ? (addr_i[REGION_W-1:0] & MASK[g]) : '0;
  end

  always_comb begin
    offset_o = '0;
    for (int i = 0; i < NUM_TGT; i++) offset_o = offset_o | off_part[i];
  end
endmodule

// File: rtl/boot_map_checker.sv
module boot_map_checker
  import boot_map_pkg::*;
(
  input logic                clk_i,
  input logic                rst_ni,
  input logic [ADDR_W-1:0]   addr_i,
  input logic                valid_i,
  input logic                set_boot_i,
  input logic                clr_boot_i,
  input logic                erase_i,
  input logic [NUM_TGT-1:0]  sel_o,
  input logic [REGION_W-1:0] offset_o,
  input logic                abort_o,
  input logic                boot_sel_q,
  input logic                remap_q
);
  AST_ROM_FIXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && addr_i[31:20] == 12'h003) |-> sel_o == 3'b100); // R1
  AST_ABORT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && addr_i[31:28] == 4'h0 && addr_i[27:22] != 6'h0) |-> (abort_o && sel_o == '0)); // R2
  AST_OUTSIDE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i[31:28] != 4'h0) |-> (!abort_o && sel_o == '0)); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> (sel_o == '0 && !abort_o && offset_o == '0)); // R4
  AST_ALIAS_ROM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && addr_i[31:20] == 12'h000 && !remap_q && !boot_sel_q) |-> sel_o == 3'b100); // R5
  AST_ALIAS_FLASH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && addr_i[31:20] == 12'h000 && !remap_q && boot_sel_q) |-> sel_o == 3'b001); // R6
  AST_ALIAS_SRAM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && addr_i[31:20] == 12'h000 && remap_q) |-> sel_o == 3'b010); // R7
  AST_REMAP_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    remap_q |=> remap_q); // R8
  AST_CLEAR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_boot_i || erase_i) |=> !boot_sel_q); // R9
  AST_SET_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_boot_i && !clr_boot_i && !erase_i) |=> boot_sel_q); // R9
  AST_BOOT_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_boot_i && !clr_boot_i && !erase_i) |=> $stable(boot_sel_q)); // R10
  AST_ONE_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({sel_o, abort_o})); // R12
  AST_NO_OFFSET_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_o == '0) |-> offset_o == '0); // R11
endmodule

bind boot_map_decoder boot_map_checker u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .addr_i     (addr_i),
  .valid_i    (valid_i),
  .set_boot_i (set_boot_i),
  .clr_boot_i (clr_boot_i),
  .erase_i    (erase_i),
  .sel_o      (sel_o),
  .offset_o   (offset_o),
  .abort_o    (abort_o),
  .boot_sel_q (boot_sel_q),
  .remap_q    (remap_q)
);

// File: tb/boot_map_decoder_tb_top.sv
module boot_map_decoder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYCLES = 5000;
  localparam logic [2:0] S_NONE = 3'b000, S_FL = 3'b001, S_SR = 3'b010, S_RO = 3'b100;

  typedef struct packed {
    logic [31:0] addr;
    logic [2:0]  sel;
    logic        abort;
    logic [19:0] off;
  } vec_t;

  // default state: boot bit 0, no remap
  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{32'h0000_1234, S_RO,   1'b0, 20'h01234},
    '{32'h0000_0000, S_RO,   1'b0, 20'h00000},
    '{32'h000F_FFFF, S_RO,   1'b0, 20'h0FFFF},
    '{32'h0014_0123, S_FL,   1'b0, 20'h00123},
    '{32'h0023_4567, S_SR,   1'b0, 20'h04567},
    '{32'h003F_FFFF, S_RO,   1'b0, 20'h0FFFF},
    '{32'h0040_0000, S_NONE, 1'b1, 20'h00000},
    '{32'h0FFF_FFFC, S_NONE, 1'b1, 20'h00000},
    '{32'h1000_0000, S_NONE, 1'b0, 20'h00000},
    '{32'hFFFF_FFFF, S_NONE, 1'b0, 20'h00000}
  };

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [31:0] addr = '0;
  logic valid = 1'b0, remap = 1'b0, set_b = 1'b0, clr_b = 1'b0, erase = 1'b0;
  logic [2:0] sel;
  logic [19:0] off;
  logic abort;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  boot_map_decoder dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .valid_i(valid),
    .remap_i(remap), .set_boot_i(set_b), .clr_boot_i(clr_b), .erase_i(erase),
    .sel_o(sel), .offset_o(off), .abort_o(abort)
  );

  task automatic chk(input string req, input logic [2:0] es, input logic ea, input logic [19:0] eo);
    checks++;
    if (sel !== es || abort !== ea || off !== eo) begin
      errors++;
      $display("FAIL %s addr=%h sel=%b/%b abort=%b/%b off=%h/%h",
               req, addr, sel, es, abort, ea, off, eo);
    end
  endtask

  task automatic look(input logic [31:0] a, input string req, input logic [2:0] es,
                      input logic ea, input logic [19:0] eo);
    @(negedge clk);
    addr = a; valid = 1'b1;
    #1 chk(req, es, ea, eo);
  endtask

  // pulse for one cycle; check the alias decode in the pulse cycle (old state)
  task automatic pulse(input logic r, input logic s, input logic c, input logic e,
                       input logic [2:0] old_sel);
    @(negedge clk);
    addr = 32'h0000_0040; valid = 1'b1;
    remap = r; set_b = s; clr_b = c; erase = e;
    #1 chk("R10", old_sel, 1'b0, 20'h00040);
    @(negedge clk);
    remap = 1'b0; set_b = 1'b0; clr_b = 1'b0; erase = 1'b0;
  endtask

  initial begin
    // R5: async reset state
    addr = 32'h0000_0010; valid = 1'b1;
    #2 chk("R5", S_RO, 1'b0, 20'h00010);
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      look(VECS[i].addr, "R1/R2/R3/R11", VECS[i].sel, VECS[i].abort, VECS[i].off);
      checks++;
      if ($countones({sel, abort}) > 1) begin
        errors++;
        $display("FAIL R12 sel=%b abort=%b expected at most one", sel, abort);
      end
    end

    // R4
    @(negedge clk); addr = 32'h0010_0000; valid = 1'b0;
    #1 chk("R4", S_NONE, 1'b0, 20'h0);
    @(negedge clk); addr = 32'h0050_0000;
    #1 chk("R4", S_NONE, 1'b0, 20'h0);

    // R6 / R10: set boot bit
    pulse(1'b0, 1'b1, 1'b0, 1'b0, S_RO);
    look(32'h0005_0010, "R6", S_FL, 1'b0, 20'h10010);
    look(32'h0030_0004, "R1", S_RO, 1'b0, 20'h00004);

    // R9: clear beats set, erase clears
    pulse(1'b0, 1'b1, 1'b1, 1'b0, S_FL);
    look(32'h0000_0100, "R9", S_RO, 1'b0, 20'h00100);
    pulse(1'b0, 1'b1, 1'b0, 1'b0, S_RO);
    pulse(1'b0, 1'b0, 1'b0, 1'b1, S_FL);
    look(32'h0000_0100, "R9", S_RO, 1'b0, 20'h00100);
    pulse(1'b0, 1'b1, 1'b0, 1'b1, S_RO);
    look(32'h0000_0100, "R9", S_RO, 1'b0, 20'h00100);

    // R7: remap with boot bit set
    pulse(1'b0, 1'b1, 1'b0, 1'b0, S_RO);
    pulse(1'b1, 1'b0, 1'b0, 1'b0, S_FL);
    look(32'h0003_8888, "R7", S_SR, 1'b0, 20'h08888);
    look(32'h0020_8888, "R7", S_SR, 1'b0, 20'h08888);
    look(32'h0017_0001, "R1", S_FL, 1'b0, 20'h30001);

    // R8: sticky against further pulses
    pulse(1'b1, 1'b0, 1'b1, 1'b0, S_SR);
    look(32'h0000_0002, "R8", S_SR, 1'b0, 20'h00002);
    pulse(1'b0, 1'b1, 1'b0, 1'b1, S_SR);
    look(32'h0000_0002, "R8", S_SR, 1'b0, 20'h00002);

    // R8/R5: only reset clears remap, boot bit returns to default
    @(negedge clk); rst_ni = 1'b0;
    @(negedge clk); rst_ni = 1'b1;
    look(32'h0000_0002, "R8", S_RO, 1'b0, 20'h00002);
    done = 1'b1;
  end

  initial begin
    int n = 0;
    while (!done && n < WDOG_CYCLES) begin
      @(posedge clk); n++;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired after %0d cycles, expected completion", n);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule